// File: doc/BRIEF.md
# Lockable Instruction Cache

This block is a read-only 4 KB instruction cache. It is split into four segments, and each segment is a fully associative set of 64 lines of four 32-bit words. The core raises a one-cycle fetch strobe with a physical byte address and a cacheable qualifier. The cache answers with a one-cycle ready pulse that carries the instruction word. When a lookup misses, the cache goes to external memory in one of two ways:

- A four-word line fetch, which refills one way of the addressed segment.
- A single-word fetch that bypasses the cache and leaves its contents unchanged.

Software uses three controls:

- An enable input. The cache is off after reset.
- A lockdown base. Ways numbered below the base in every segment are kept out of replacement, but they still answer lookups.
- A flush strobe, which invalidates every line, locked or not.

Replacement takes the lowest-numbered invalid unlocked way of the segment. When the segment has no such way, a free-running 16-bit LFSR is scaled into the unlocked range.

Top module: `icache_lockable`

## Requirements
- R1: While reset is high and in the cycle after it, fetch_ready and mem_req are low. All lines are invalid and the cache is disabled.
- R2: While cache_en is low, every fetch becomes a single-word fetch (mem_line=0), and nothing is allocated.
- R3: Take an enabled, cacheable fetch that misses while an unlocked way exists. It produces exactly one mem_req pulse with mem_line=1 and mem_addr equal to the fetch address with bits [3:0] cleared. Memory then returns the four words in ascending address order, one per mem_rvalid cycle.
- R4: During a line fetch, fetch_ready pulses, with the requested word, in the cycle after the mem_rvalid beat that carried that word.
- R5: A hit raises fetch_ready for exactly one cycle, two cycles after the cycle in which the strobe is sampled. A hit issues no mem_req.
- R6: A hit returns the cached word whatever the value of fetch_cacheable.
- R7: A fetch that misses with fetch_cacheable low issues a single-word mem_req (mem_line=0) at the word-aligned address. It returns that word and leaves the cache unchanged, so repeating the fetch misses again.
- R8: Address bits [5:4] select the segment, bits [3:2] select the word, and bits [31:6] are the tag. Equal tags in different segments are different lines.
- R9: A flush invalidates every line, including locked ones.
- R10: Ways below lock_base are never chosen as victims, and lines held in them keep hitting. A fill goes to the lowest invalid way at or above lock_base. If there is none, it goes to a pseudo-random way in [lock_base, 63].
- R11: When lock_base is 64 or more, a cacheable miss is served as a single-word fetch.
- R12: A fetch strobe that arrives while a fetch is in progress is ignored. It causes no extra memory request and no extra ready pulse.
- R13: A line becomes valid only when its fourth word has been stored. A flush during a fill still returns the requested word, but the line does not become valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Enables lookup and allocation |
| lock_base | input | 7 | Number of locked low ways per segment (64 or more: all locked) |
| flush | input | 1 | Invalidate-all strobe |
| fetch_req | input | 1 | One-cycle fetch strobe, sampled only when idle |
| fetch_addr | input | 32 | Physical byte address of the instruction |
| fetch_cacheable | input | 1 | Allows allocation on a miss |
| fetch_ready | output | 1 | One-cycle pulse, fetch_data valid |
| fetch_data | output | 32 | Returned instruction word |
| mem_req | output | 1 | One-cycle external read command |
| mem_line | output | 1 | 1: four-word line fetch, 0: single word |
| mem_addr | output | 32 | External read address |
| mem_rvalid | input | 1 | External read beat valid |
| mem_rdata | input | 32 | External read beat data |

## Verification
Each strobe is issued on a falling edge. A hit must show fetch_ready exactly two cycles later, with no memory command in between. A miss must raise mem_req one cycle after the lookup cycle. Its ready pulse is due one cycle after the memory model drives the beat that carries the requested word, so the bench records the cycle number of that beat and compares the cycle of the ready pulse against it. The bench keeps its own model of which line sits in which way, using the lowest-free-way rule. From that model it predicts hit, line fetch or bypass for every fetch. After each fetch it waits out the remaining beats and counts any stray ready pulses before it issues the next stimulus.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned SEGS       = 4;
    localparam int unsigned WAYS       = 64;
    localparam int unsigned LINE_WORDS = 4;
    localparam int unsigned RND_W      = 16;
    localparam logic [15:0] LFSR_TAPS  = 16'hB400;

    localparam int unsigned OFF_W  = $clog2(DATA_W / 8);
    localparam int unsigned WSEL_W = $clog2(LINE_WORDS);
    localparam int unsigned SEG_W  = $clog2(SEGS);
    localparam int unsigned WAY_W  = $clog2(WAYS);
    localparam int unsigned LOCK_W = WAY_W + 1;
    localparam int unsigned TAG_W  = ADDR_W - SEG_W - WSEL_W - OFF_W;
    localparam int unsigned IDX_W  = SEG_W + WAY_W + WSEL_W;
    localparam int unsigned DEPTH  = SEGS * WAYS * LINE_WORDS;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FILL,
        ST_SINGLE
    } ic_state_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SEG_W-1:0]  seg;
        logic [WSEL_W-1:0] wsel;
    } ic_addr_t;

    function automatic ic_addr_t split_addr(input logic [ADDR_W-1:0] a);
        ic_addr_t f;
        f.tag  = a[ADDR_W-1 -: TAG_W];
        f.seg  = a[OFF_W+WSEL_W +: SEG_W];
        f.wsel = a[OFF_W +: WSEL_W];
        return f;
    endfunction

    function automatic logic [ADDR_W-1:0] line_addr(input ic_addr_t f);
        return {f.tag, f.seg, {(WSEL_W + OFF_W){1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] word_addr(input ic_addr_t f);
        return {f.tag, f.seg, f.wsel, {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/icache_lfsr.sv
module icache_lfsr
    import icache_pkg::*;
#(
    parameter logic [RND_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [RND_W-1:0] value
);

    logic feedback;

    assign feedback = ^(value & LFSR_TAPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= SEED;
        end else begin
            value <= {value[RND_W-2:0], feedback};
        end
    end

endmodule

// File: rtl/icache_victim.sv
module icache_victim
    import icache_pkg::*;
(
    input  logic [WAYS-1:0]   valid_row,
    input  logic [LOCK_W-1:0] lock_base,
    input  logic [RND_W-1:0]  rnd,
    output logic [WAY_W-1:0]  victim,
    output logic              victim_ok
);

    localparam int unsigned PROD_W = RND_W + LOCK_W;

    logic              free_found;
    logic [WAY_W-1:0]  free_way;
    logic [LOCK_W-1:0] span;
    logic [PROD_W-1:0] scaled;
    logic [LOCK_W-1:0] rand_way;

    // Lowest invalid way that is not locked.
    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_row[i] && (LOCK_W'(i) >= lock_base)) begin
                free_found = 1'b1;
                free_way   = WAY_W'(i);
            end
        end
    end

    // Scale the random value into [lock_base, WAYS-1].
    always_comb begin
        victim_ok = lock_base < LOCK_W'(WAYS);
        span      = victim_ok ? (LOCK_W'(WAYS) - lock_base) : '0;
        scaled    = PROD_W'(rnd) * PROD_W'(span);
        rand_way  = lock_base + scaled[PROD_W-1 -: LOCK_W];
        victim    = free_found ? free_way : rand_way[WAY_W-1:0];
    end

endmodule

// File: rtl/icache_tag_cam.sv
module icache_tag_cam
    import icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [SEG_W-1:0]  lk_seg,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    output logic [WAYS-1:0]   lk_valid,
    input  logic              clr_en,
    input  logic              set_en,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [TAG_W-1:0]  wr_tag
);

    logic [TAG_W-1:0] tag_q [SEGS][WAYS];
    logic [WAYS-1:0]  vld_q [SEGS];
    logic [WAYS-1:0]  match;

    assign lk_valid = vld_q[lk_seg];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = lk_valid[w] && (tag_q[lk_seg][w] == lk_tag);
    end

    always_comb begin
        lk_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                lk_way = lk_way | WAY_W'(w);
            end
        end
    end

    assign lk_hit = |match;

    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[wr_seg][wr_way] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < SEGS; s++) begin
                vld_q[s] <= '0;
            end
        end else begin
            if (clr_en) begin
                vld_q[wr_seg][wr_way] <= 1'b0;
            end
            if (set_en) begin
                vld_q[wr_seg][wr_way] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/icache_data_ram.sv
module icache_data_ram
    import icache_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/icache_lockable.sv
module icache_lockable
    import icache_pkg::*;
#(
    parameter logic [RND_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cache_en,
    input  logic [LOCK_W-1:0] lock_base,
    input  logic              flush,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_cacheable,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic              mem_line,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    ic_state_e          state;
    ic_addr_t           cur;
    logic               cur_cacheable;
    logic [WAY_W-1:0]   fill_way;
    logic [WSEL_W-1:0]  beat;
    logic               fill_cancel;
    logic               rdy_q;
    logic [DATA_W-1:0]  data_q;
    logic               mreq_q;
    logic               mline_q;
    logic [ADDR_W-1:0]  maddr_q;

    logic               cam_hit;
    logic [WAY_W-1:0]   hit_way;
    logic [WAYS-1:0]    row_valid;
    logic [WAY_W-1:0]   victim;
    logic               victim_ok;
    logic [RND_W-1:0]   rnd;
    logic [WAY_W-1:0]   cam_way;
    logic [DATA_W-1:0]  ram_rd;
    logic               lookup_hit;
    logic               alloc;
    logic               ram_we;
    logic               last_beat;
    logic               set_en;

    assign lookup_hit = cam_hit && cache_en;
    assign alloc      = (state == ST_LOOK) && !lookup_hit && cache_en
                        && cur_cacheable && victim_ok;
    assign ram_we     = (state == ST_FILL) && mem_rvalid;
    assign last_beat  = beat == WSEL_W'(LINE_WORDS - 1);
    assign set_en     = ram_we && last_beat && !fill_cancel && !flush;
    assign cam_way    = (state == ST_FILL) ? fill_way : victim;

    icache_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .value (rnd)
    );

    icache_tag_cam u_cam (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .lk_seg   (cur.seg),
        .lk_tag   (cur.tag),
        .lk_hit   (cam_hit),
        .lk_way   (hit_way),
        .lk_valid (row_valid),
        .clr_en   (alloc),
        .set_en   (set_en),
        .wr_seg   (cur.seg),
        .wr_way   (cam_way),
        .wr_tag   (cur.tag)
    );

    icache_victim u_victim (
        .valid_row (row_valid),
        .lock_base (lock_base),
        .rnd       (rnd),
        .victim    (victim),
        .victim_ok (victim_ok)
    );

    icache_data_ram u_ram (
        .clk     (clk),
        .we      (ram_we),
        .wr_idx  ({cur.seg, fill_way, beat}),
        .wr_data (mem_rdata),
        .rd_idx  ({cur.seg, hit_way, cur.wsel}),
        .rd_data (ram_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cur           <= '0;
            cur_cacheable <= 1'b0;
            fill_way      <= '0;
            beat          <= '0;
            fill_cancel   <= 1'b0;
            rdy_q         <= 1'b0;
            data_q        <= '0;
            mreq_q        <= 1'b0;
            mline_q       <= 1'b0;
            maddr_q       <= '0;
        end else begin
            rdy_q  <= 1'b0;
            mreq_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (fetch_req) begin
                        cur           <= split_addr(fetch_addr);
                        cur_cacheable <= fetch_cacheable;
                        state         <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (lookup_hit) begin
                        rdy_q  <= 1'b1;
                        data_q <= ram_rd;
                        state  <= ST_IDLE;
                    end else if (alloc) begin
                        mreq_q      <= 1'b1;
                        mline_q     <= 1'b1;
                        maddr_q     <= line_addr(cur);
                        fill_way    <= victim;
                        beat        <= '0;
                        fill_cancel <= flush;
                        state       <= ST_FILL;
                    end else begin
                        mreq_q  <= 1'b1;
                        mline_q <= 1'b0;
                        maddr_q <= word_addr(cur);
                        state   <= ST_SINGLE;
                    end
                end
                ST_FILL: begin
                    if (flush) begin
                        fill_cancel <= 1'b1;
                    end
                    if (mem_rvalid) begin
                        if (beat == cur.wsel) begin
                            rdy_q  <= 1'b1;
                            data_q <= mem_rdata;
                        end
                        beat <= beat + 1'b1;
                        if (last_beat) begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_SINGLE: begin
                    if (mem_rvalid) begin
                        rdy_q  <= 1'b1;
                        data_q <= mem_rdata;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign fetch_ready = rdy_q;
    assign fetch_data  = data_q;
    assign mem_req     = mreq_q;
    assign mem_line    = mline_q;
    assign mem_addr    = maddr_q;

endmodule

// File: rtl/icache_lockable_chk.sv
module icache_lockable_chk
    import icache_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cache_en,
    input logic [LOCK_W-1:0] lock_base,
    input logic              fetch_ready,
    input logic              mem_req,
    input logic              mem_line,
    input logic [ADDR_W-1:0] mem_addr,
    input ic_state_e         state,
    input logic              alloc,
    input logic [WAY_W-1:0]  victim,
    input logic              cur_cacheable
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!fetch_ready && !mem_req));

    assert_line_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_line) |-> $past(cache_en));

    assert_line_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_line) |-> (mem_addr[OFF_W+WSEL_W-1:0] == '0));

    assert_mem_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        fetch_ready |=> !fetch_ready);

    assert_line_cacheable_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_line) |-> cur_cacheable);

    assert_victim_unlocked_R10: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_LOOK) && alloc) |-> ({1'b0, victim} >= lock_base));

    assert_full_lock_bypass_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_line) |-> ($past(lock_base) < LOCK_W'(WAYS)));

endmodule

bind icache_lockable icache_lockable_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cache_en      (cache_en),
    .lock_base     (lock_base),
    .fetch_ready   (fetch_ready),
    .mem_req       (mem_req),
    .mem_line      (mem_line),
    .mem_addr      (mem_addr),
    .state         (state),
    .alloc         (alloc),
    .victim        (victim),
    .cur_cacheable (cur_cacheable)
);

// File: tb/icache_lockable_test.sv
module icache_lockable_test;
    import icache_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cache_en = 1'b0;
    logic [LOCK_W-1:0] lock_base = '0;
    logic              flush = 1'b0;
    logic              fetch_req = 1'b0;
    logic [31:0]       fetch_addr = '0;
    logic              fetch_cacheable = 1'b0;
    logic              fetch_ready;
    logic [31:0]       fetch_data;
    logic              mem_req;
    logic              mem_line;
    logic [31:0]       mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;

    always #5 clk = ~clk;

    icache_lockable uut (
        .clk             (clk),
        .rst             (rst),
        .cache_en        (cache_en),
        .lock_base       (lock_base),
        .flush           (flush),
        .fetch_req       (fetch_req),
        .fetch_addr      (fetch_addr),
        .fetch_cacheable (fetch_cacheable),
        .fetch_ready     (fetch_ready),
        .fetch_data      (fetch_data),
        .mem_req         (mem_req),
        .mem_line        (mem_line),
        .mem_addr        (mem_addr),
        .mem_rvalid      (mem_rvalid),
        .mem_rdata       (mem_rdata)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] word_at(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return (w * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory responder: two idle cycles, then one beat per cycle.
    int          m_left = 0;
    int          m_wait = 0;
    int          req_count = 0;
    int          want_cyc = -1;
    logic [31:0] m_ptr = '0;
    logic [31:0] last_addr = '0;
    logic        last_line = 1'b0;
    logic [31:0] mem_target = '0;

    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (m_left > 0) begin
                if (m_wait > 0) begin
                    m_wait--;
                end else begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = word_at(m_ptr);
                    if (m_ptr == mem_target) want_cyc = cyc;
                    m_ptr  = m_ptr + 32'd4;
                    m_left--;
                end
            end
            if (mem_req) begin
                req_count++;
                last_addr = mem_addr;
                last_line = mem_line;
                m_ptr     = mem_addr;
                m_left    = mem_line ? 4 : 1;
                m_wait    = 2;
            end
        end
    end

    // Reference model of residency.
    bit          mv [4][64];
    logic [31:0] ml [4][64];
    int          lock_m = 0;
    bit          en_m = 1'b0;

    task automatic model_clear();
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 64; w++) mv[s][w] = 1'b0;
    endtask

    task automatic set_ctl(input bit en, input int lock);
        cache_en  = en;
        lock_base = LOCK_W'(lock);
        en_m      = en;
        lock_m    = lock;
        @(negedge clk);
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_clear();
        @(negedge clk);
    endtask

    task automatic do_fetch(input logic [31:0] a, input bit cach, input string req,
                            input bit poke, input bit flush_mid);
        int          seg;
        logic [31:0] lb;
        logic [31:0] tw;
        bit          hit;
        bit          exp_line;
        bit          found;
        int          fw;
        int          c0;
        int          r0;
        int          rcyc;
        int          extra;
        logic [31:0] rdata;
        seg   = int'(a[5:4]);
        lb    = {a[31:4], 4'h0};
        tw    = {a[31:2], 2'b00};
        hit   = 1'b0;
        found = 1'b0;
        fw    = 0;
        rcyc  = -1;
        extra = 0;
        rdata = '0;
        if (en_m)
            for (int w = 0; w < 64; w++)
                if (mv[seg][w] && ml[seg][w] == lb) hit = 1'b1;
        exp_line = !hit && en_m && cach && (lock_m < 64);
        if (exp_line) begin
            for (int w = 63; w >= lock_m; w--)
                if (!mv[seg][w]) begin found = 1'b1; fw = w; end
            if (found) begin
                mv[seg][fw] = 1'b1;
                ml[seg][fw] = lb;
            end else begin
                for (int w = lock_m; w < 64; w++) mv[seg][w] = 1'b0;
            end
        end
        mem_target      = tw;
        want_cyc        = -1;
        r0              = req_count;
        fetch_addr      = a;
        fetch_cacheable = cach;
        fetch_req       = 1'b1;
        c0              = cyc;
        @(negedge clk);
        fetch_req = 1'b0;
        for (int k = 1; k < 60 && rcyc < 0; k++) begin
            if (fetch_ready) begin
                rcyc  = cyc;
                rdata = fetch_data;
            end
            flush = (flush_mid && k == 4);
            if (poke && k == 3) begin
                fetch_req  = 1'b1;
                fetch_addr = a ^ 32'h100;
            end else begin
                fetch_req = 1'b0;
            end
            @(negedge clk);
        end
        flush     = 1'b0;
        fetch_req = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (fetch_ready) extra++;
            @(negedge clk);
        end
        if (flush_mid) model_clear();

        check(rcyc >= 0, req, "ready seen", rcyc >= 0, 1);
        check(rdata == word_at(tw), req, "data", rdata, word_at(tw));
        check(extra == 0, req, "stray ready pulses", extra, 0);
        if (hit) begin
            check(rcyc == c0 + 2, req, "hit latency", rcyc - c0, 2);
            check(req_count == r0, req, "memory requests on hit", req_count - r0, 0);
        end else begin
            check(req_count == r0 + 1, req, "memory requests", req_count - r0, 1);
            check(last_line == exp_line, req, "line or single", last_line, exp_line);
            check(last_addr == (exp_line ? lb : tw), req, "memory address",
                  last_addr, exp_line ? lb : tw);
            check(rcyc == want_cyc + 1, req, "ready after beat", rcyc, want_cyc + 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run timed out", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        // R1: quiet outputs under reset
        check(fetch_ready == 1'b0, "R1", "fetch_ready in reset", fetch_ready, 0);
        check(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
        rst = 1'b0;
        @(negedge clk);
        check(fetch_ready == 1'b0 && mem_req == 1'b0, "R1", "outputs after reset",
              {fetch_ready, mem_req}, 0);

        // R2: disabled cache bypasses and allocates nothing
        do_fetch(32'h0000_1008, 1'b1, "R2", 1'b0, 1'b0);
        do_fetch(32'h0000_1008, 1'b1, "R2", 1'b0, 1'b0);

        // R3, R4: line fill with the requested word in the middle of the line
        set_ctl(1'b1, 0);
        do_fetch(32'h0000_1008, 1'b1, "R3", 1'b0, 1'b0);
        // R5: hit on another word of the filled line
        do_fetch(32'h0000_100C, 1'b1, "R5", 1'b0, 1'b0);
        // R6: hit with the qualifier low
        do_fetch(32'h0000_1000, 1'b0, "R6", 1'b0, 1'b0);

        // R7: uncacheable miss stays a miss
        do_fetch(32'h0000_2004, 1'b0, "R7", 1'b0, 1'b0);
        do_fetch(32'h0000_2004, 1'b0, "R7", 1'b0, 1'b0);

        // R8: same tag, other segment is a different line
        do_fetch(32'h0000_1018, 1'b1, "R8", 1'b0, 1'b0);
        do_fetch(32'h0000_101C, 1'b1, "R8", 1'b0, 1'b0);
        do_fetch(32'h0000_1004, 1'b1, "R8", 1'b0, 1'b0);

        // R4: requested word is the last one of the line
        do_fetch(32'h0000_500C, 1'b1, "R4", 1'b0, 1'b0);

        // R12: strobe during a fill is ignored
        do_fetch(32'h0000_3020, 1'b1, "R12", 1'b1, 1'b0);
        do_fetch(32'h0000_3120, 1'b1, "R12", 1'b0, 1'b0);

        // R9: flush drops the resident lines
        do_flush();
        do_fetch(32'h0000_100C, 1'b1, "R9", 1'b0, 1'b0);

        // R13: flush during a fill leaves the line invalid
        do_fetch(32'h0000_4030, 1'b1, "R13", 1'b0, 1'b1);
        do_fetch(32'h0000_4030, 1'b1, "R13", 1'b0, 1'b0);

        // R10: lock ways 0..3 of segment 0, then force a replacement
        do_flush();
        for (int k = 0; k < 4; k++)
            do_fetch(32'h0001_0000 + 32'(k * 64), 1'b1, "R10", 1'b0, 1'b0);
        set_ctl(1'b1, 4);
        for (int k = 4; k < 65; k++)
            do_fetch(32'h0001_0008 + 32'(k * 64), 1'b1, "R10", 1'b0, 1'b0);
        for (int k = 0; k < 4; k++)
            do_fetch(32'h0001_0004 + 32'(k * 64), 1'b1, "R10", 1'b0, 1'b0);

        // R11: all ways locked gives single-word fetches, locked lines still hit
        set_ctl(1'b1, 64);
        do_fetch(32'h0001_0000 + 32'(70 * 64), 1'b1, "R11", 1'b0, 1'b0);
        do_fetch(32'h0001_0040, 1'b1, "R11", 1'b0, 1'b0);

        // R9: locked lines are flushed too
        do_flush();
        do_fetch(32'h0001_0000, 1'b1, "R9", 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule